// File: doc/BRIEF.md
# Cache Hit and Miss Event Monitor

This block keeps two performance counters beside a cache lookup stage. One counts lookups that hit and the other counts lookups that miss. The lookup stage raises a single-cycle strobe for each event. A control word from the register file turns each counter on or off and can hold it at zero. Both running totals are always visible as plain outputs, so software can read them at any time without disturbing the counting.

The two counters never wrap. A count that reaches the all-ones value stays there until it is cleared, so a long measurement never reads back as a small number. When a counter's enable is removed, it freezes at its current value. Its clear bit is level-sensitive: while the bit is set the count is forced to zero and stays there, and counting starts again from zero once the bit is released. The block uses one reset input, `rst_n`. It is active low and acts on the rising clock edge.

Top module: `hm_monitor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both counts become zero at that edge, whatever the strobes and the control word are.
- R2: On each rising edge at which a counter's enable bit and its event strobe are both high, and its clear bit is low, the counter grows by exactly one, provided it is below the all-ones value.
- R3: While a counter's enable bit is low and its clear bit is low, its count does not change, even when its strobe pulses.
- R4: The counters are independent. A hit strobe changes only `hit_count`. A miss strobe changes only `miss_count`. Each counter's control bits act on that counter alone.
- R5: While a counter's clear bit is high, its count is zero after every edge. The clear bit wins over the enable bit and the strobe.
- R6: When a clear bit is released with the enable still set, the next counted event gives a count of one.
- R7: A counter at the all-ones value keeps that value when further enabled events arrive. It never wraps to zero.
- R8: Control word layout: bit 0 enables the hit counter, bit 1 enables the miss counter, bit 2 clears the hit counter and bit 3 clears the miss counter. Each clear bit sits two positions above its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| hit_stb | input | 1 | One-cycle pulse per cache hit |
| miss_stb | input | 1 | One-cycle pulse per cache miss |
| ctl | input | 4 | Enable and clear bits, laid out as in R8 |
| hit_count | output | CNT_W (32) | Saturating hit total |
| miss_count | output | CNT_W (32) | Saturating miss total |

## Verification
The assertions assume that the lookup stage never reports a hit and a miss in the same cycle. A property at the top guards this assumption, and every stimulus vector and directed step drives at most one strobe per cycle. The assertions also assume that the control word can change on any cycle. The stimulus therefore sets and releases enable and clear bits in every combination, including clear and enable together. Saturation is reached on a second instance built with a narrow count width, because filling 32 bits by counting would take far too long. The counter logic is the same at any width, so this instance exercises the same saturation behaviour.

// File: rtl/hm_mon_pkg.sv
// Shared constants for the hit/miss monitor: counter indices and the
// layout of the control word (each clear bit sits two above its enable).
package hm_mon_pkg;
    localparam int NUM_CNT   = 2;
    localparam int IDX_HIT   = 0;
    localparam int IDX_MISS  = 1;
    localparam int CLR_SHIFT = 2;
    localparam int CTL_W     = NUM_CNT + CLR_SHIFT;
endpackage

// File: rtl/hm_ctl_decode.sv
// Splits the control word into per-counter enable and clear vectors.
// Assumes the control word is already synchronous to clk.
module hm_ctl_decode
    import hm_mon_pkg::*;
(
    input  logic [CTL_W-1:0]   ctl,
    output logic [NUM_CNT-1:0] en,
    output logic [NUM_CNT-1:0] clr
);
    // Purpose: pick enable bits from the low positions and clears from CLR_SHIFT up.
    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            en[i]  = ctl[i];
            clr[i] = ctl[i + CLR_SHIFT];
        end
    end
endmodule

// File: rtl/hm_sat_counter.sv
// One saturating event counter. A level clear has priority over counting.
// Assumes ev is a one-cycle strobe per event; reset is synchronous, active low.
module hm_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             ev,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: reset, clear, or add one to the count while below the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && ev && (cnt != CNT_MAX))
            cnt <= cnt + 1'b1;
    end

    // R5: a held clear leaves the count at zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R7: the maximum value is sticky
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX));

    // R3: disabled counter holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

    // R2: counted event adds exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev && !clr && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/hm_monitor.sv
// Cache hit and miss monitor: two independent saturating counters steered
// by a control word of enable and clear bits. Assumes the hit and miss
// strobes are never high together; reset is synchronous, active low.
module hm_monitor
    import hm_mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_stb,
    input  logic             miss_stb,
    input  logic [3:0]       ctl,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    logic [NUM_CNT-1:0] en;
    logic [NUM_CNT-1:0] clr;
    logic [NUM_CNT-1:0] ev;
    logic [CNT_W-1:0]   cnt [NUM_CNT];

    hm_ctl_decode u_dec (
        .ctl (ctl[CTL_W-1:0]),
        .en  (en),
        .clr (clr)
    );

    // Purpose: gather the event strobes by counter index.
    always_comb begin
        ev           = '0;
        ev[IDX_HIT]  = hit_stb;
        ev[IDX_MISS] = miss_stb;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        hm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en[g]),
            .clr   (clr[g]),
            .ev    (ev[g]),
            .cnt   (cnt[g])
        );
    end

    assign hit_count  = cnt[IDX_HIT];
    assign miss_count = cnt[IDX_MISS];

    // R4: input assumption, one lookup outcome per cycle
    a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_stb && miss_stb));

    // R4: a miss with no hit never moves the hit total
    a_r4_hit_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_stb && !ctl[2]) |=> $stable(hit_count));

    // R1: reset zeroes both totals
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> ((hit_count == '0) && (miss_count == '0)));
endmodule

// File: tb/sim_hm_monitor.sv
module sim_hm_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_stb = 1'b0, miss_stb = 1'b0;
    logic [3:0]  ctl = 4'b0;
    logic [31:0] hit_count, miss_count;
    logic        s_hit = 1'b0, s_miss = 1'b0;
    logic [3:0]  s_ctl = 4'b0;
    logic [3:0]  s_hcnt, s_mcnt;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    hm_monitor u0 (.clk(clk), .rst_n(rst_n), .hit_stb(hit_stb), .miss_stb(miss_stb),
                   .ctl(ctl), .hit_count(hit_count), .miss_count(miss_count));

    hm_monitor #(.CNT_W(4)) u1 (.clk(clk), .rst_n(rst_n), .hit_stb(s_hit), .miss_stb(s_miss),
                   .ctl(s_ctl), .hit_count(s_hcnt), .miss_count(s_mcnt));

    // {hit, miss, ctl[3:0], expected hit, expected miss}
    localparam int NV = 16;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'b0001, 32'd1, 32'd0},
        {1'b1, 1'b0, 4'b0001, 32'd2, 32'd0},
        {1'b0, 1'b1, 4'b0001, 32'd2, 32'd0},
        {1'b0, 1'b1, 4'b0011, 32'd2, 32'd1},
        {1'b0, 1'b0, 4'b0011, 32'd2, 32'd1},
        {1'b1, 1'b0, 4'b0010, 32'd2, 32'd1},
        {1'b0, 1'b1, 4'b0010, 32'd2, 32'd2},
        {1'b1, 1'b0, 4'b0111, 32'd0, 32'd2},
        {1'b1, 1'b0, 4'b0111, 32'd0, 32'd2},
        {1'b0, 1'b1, 4'b0111, 32'd0, 32'd3},
        {1'b1, 1'b0, 4'b0011, 32'd1, 32'd3},
        {1'b0, 1'b1, 4'b1011, 32'd1, 32'd0},
        {1'b0, 1'b1, 4'b1000, 32'd1, 32'd0},
        {1'b0, 1'b1, 4'b0010, 32'd1, 32'd1},
        {1'b1, 1'b0, 4'b0001, 32'd2, 32'd1},
        {1'b0, 1'b0, 4'b1100, 32'd0, 32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        hit_stb = 1'b1; ctl = 4'b0011;
        repeat (2) @(negedge clk);
        check("R1 reset hit", hit_count, 32'd0);
        check("R1 reset miss", miss_count, 32'd0);
        hit_stb = 1'b0; ctl = 4'b0000;
        rst_n = 1'b1;
        @(negedge clk);
        // Vector walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            hit_stb  = VEC[i][69];
            miss_stb = VEC[i][68];
            ctl      = VEC[i][67:64];
            @(negedge clk);
            check($sformatf("R2/R3/R4/R5/R6/R8 vec %0d hit", i), hit_count, VEC[i][63:32]);
            check($sformatf("R2/R3/R4/R5/R6/R8 vec %0d miss", i), miss_count, VEC[i][31:0]);
        end
        // R1: reset mid-run beats enabled strobes
        hit_stb = 1'b1; miss_stb = 1'b0; ctl = 4'b0011;
        repeat (3) @(negedge clk);
        check("R2 run before reset", hit_count, 32'd3);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset hit", hit_count, 32'd0);
        rst_n = 1'b1; hit_stb = 1'b0; miss_stb = 1'b1;
        @(negedge clk);
        check("R1 count after reset miss", miss_count, 32'd1);
        check("R4 hit untouched by miss", hit_count, 32'd0);
        miss_stb = 1'b0; ctl = 4'b0000;
        // R7: saturation on the narrow instance
        s_ctl = 4'b0011; s_hit = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 hit saturates", {28'd0, s_hcnt}, 32'd15);
        check("R4 miss idle while hit saturates", {28'd0, s_mcnt}, 32'd0);
        s_hit = 1'b0; s_miss = 1'b1;
        repeat (17) @(negedge clk);
        check("R7 miss saturates", {28'd0, s_mcnt}, 32'd15);
        check("R7 hit stays at max", {28'd0, s_hcnt}, 32'd15);
        s_miss = 1'b0; s_ctl = 4'b0111;
        @(negedge clk);
        check("R5 clear from max", {28'd0, s_hcnt}, 32'd0);
        check("R5 other counter keeps max", {28'd0, s_mcnt}, 32'd15);
        s_ctl = 4'b0011; s_hit = 1'b1;
        @(negedge clk);
        check("R6 restart after clear", {28'd0, s_hcnt}, 32'd1);
        s_hit = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule